// File: doc/BRIEF.md
# DRAM ECC Error Log Register Bank

This block sits beside a DRAM ECC checker and records the error events that the checker reports. A correctable event or an uncorrectable event sets a sticky flag. The failing address, the channel and the ECC syndrome of the access are captured under fixed priority rules: uncorrectable details always win over correctable ones, and the first logged error is never displaced by a later one of the same or lower rank. Three further sources set their own sticky flags: a thermal sensor trip, a locked access to non-DRAM memory, and a refresh timeout.

Software reads the log and writes to it through a single-cycle register port. The status flags clear only when software writes a one to them. A command register selects which flags may raise the system-error output, and that output is registered. The address is logged in 128-byte lines, so the input carries address bits 32:7 only.

Top module: `ecc_err_log`

## Requirements
- R1: Status word (index 0) bit positions: bit 0 correctable ECC, bit 1 uncorrectable ECC, bit 8 refresh timeout, bit 9 lock to non-DRAM, bit 11 thermal. A pulse on a source sets its bit at the next clock edge. Every other bit of the 32-bit read word is zero.
- R2: A write to index 0 clears each flag whose write-data bit is 1. A flag whose write-data bit is 0 keeps its value.
- R3: When a source event and a clearing write of the same flag land in the same cycle, the flag is set afterwards.
- R4: The command word (index 1) is read/write on bits 0, 1, 8, 9 and 11. All other bits read as zero.
- R5: `serr` is registered. It is high one cycle after any status bit and its matching command bit are both set, and low otherwise.
- R6: The address word (index 2) returns captured address bits 31:7 in bits 31:7, zeros in bits 6:1, and the captured channel in bit 0.
- R7: The extension word (index 3) returns captured address bit 32 in bit 0. Bits 31:1 are zero.
- R8: The syndrome word (index 4) returns the captured 8-bit syndrome in bits 7:0. Bits 31:8 are zero.
- R9: Details are captured from an ECC event only when neither ECC flag is set. A correctable event that arrives while the correctable flag is held leaves the details unchanged.
- R10: An uncorrectable event that arrives while only the correctable flag is held replaces the address, channel and syndrome.
- R11: While the uncorrectable flag is set, no event changes the captured details.
- R12: If correctable and uncorrectable events arrive in the same cycle with no ECC flag set, the details come from that cycle's inputs and both flags set.
- R13: After reset, every register reads zero and `serr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_evt | input | 1 | Correctable ECC error pulse |
| ue_evt | input | 1 | Uncorrectable ECC error pulse |
| err_line | input | ADDR_W-GRAIN_LSB (26) | Failing address bits 32:7 |
| err_chan | input | 1 | Channel of the failing access |
| err_syn | input | SYN_W (8) | ECC syndrome of the failing access |
| thermal_evt | input | 1 | Thermal sensor trip pulse |
| lock_evt | input | 1 | Locked access to non-DRAM memory pulse |
| refto_evt | input | 1 | Refresh timeout pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| serr | output | 1 | System-error request |

## Verification
The bench builds the block with its default parameters: a 33-bit address, 128-byte capture lines and an 8-bit syndrome. With these values the upper line bit falls into the extension word, so the split of one captured address across two read words is checked at the ports. A 26-bit line value with bit 25 set and a mixed bit pattern below it shows whether any bit is lost or shifted across the bit-7 boundary. The priority cases are driven in sequence within one run: a first correctable, a second correctable, an uncorrectable over a correctable, a correctable and a second uncorrectable after an uncorrectable, and simultaneous events.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    localparam int STS_W = 16;

    // status / command bit positions (shared layout)
    localparam int B_CE     = 0;
    localparam int B_UE     = 1;
    localparam int B_REFTO  = 8;
    localparam int B_LOCK   = 9;
    localparam int B_THERM  = 11;

    localparam logic [STS_W-1:0] STS_MASK = 16'h0B03;

    typedef enum logic [2:0] {
        SEL_STS = 3'd0,
        SEL_CMD = 3'd1,
        SEL_ADR = 3'd2,
        SEL_EXT = 3'd3,
        SEL_SYN = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        CAP_NONE = 2'd0,
        CAP_CE   = 2'd1,
        CAP_UE   = 2'd2
    } cap_kind_e;

    // sticky flag update: a new event outranks a clearing write
    function automatic logic flag_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

    // capture decision from the flags held at the start of the cycle
    function automatic cap_kind_e cap_decide(input logic ce, input logic ue,
                                             input logic ce_held, input logic ue_held);
        cap_kind_e k;
        k = CAP_NONE;
        if (ue && !ue_held)
            k = CAP_UE;
        else if (ce && !ce_held && !ue_held)
            k = CAP_CE;
        return k;
    endfunction

endpackage

// File: rtl/ecc_log_flags.sv
module ecc_log_flags
    import ecc_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [STS_W-1:0] evt,
    input  logic             clr_wr,
    input  logic [STS_W-1:0] clr_data,
    output logic [STS_W-1:0] sts
);

    for (genvar i = 0; i < STS_W; i++) begin : g_bit
        if (STS_MASK[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (rst)
                    sts[i] <= 1'b0;
                else
                    sts[i] <= flag_next(sts[i], evt[i], clr_wr & clr_data[i]);
            end
        end else begin : g_rsvd
            assign sts[i] = 1'b0;
        end
    end

endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture
    import ecc_log_pkg::*;
#(
    parameter int LINE_W = 26,
    parameter int SYN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_evt,
    input  logic              ue_evt,
    input  logic              ce_held,
    input  logic              ue_held,
    input  logic [LINE_W-1:0] line_in,
    input  logic              chan_in,
    input  logic [SYN_W-1:0]  syn_in,
    output logic [LINE_W-1:0] line_q,
    output logic              chan_q,
    output logic [SYN_W-1:0]  syn_q
);

    cap_kind_e kind;

    always_comb begin
        kind = cap_decide(ce_evt, ue_evt, ce_held, ue_held);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            chan_q <= 1'b0;
            syn_q  <= '0;
        end else if (kind != CAP_NONE) begin
            line_q <= line_in;
            chan_q <= chan_in;
            syn_q  <= syn_in;
        end
    end

endmodule

// File: rtl/ecc_log_serr.sv
module ecc_log_serr
    import ecc_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [STS_W-1:0] wdata,
    input  logic [STS_W-1:0] sts,
    output logic [STS_W-1:0] cmd,
    output logic             serr
);

    for (genvar i = 0; i < STS_W; i++) begin : g_en
        if (STS_MASK[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (rst)
                    cmd[i] <= 1'b0;
                else if (cmd_wr)
                    cmd[i] <= wdata[i];
            end
        end else begin : g_rsvd
            assign cmd[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            serr <= 1'b0;
        else
            serr <= |(sts & cmd & STS_MASK);
    end

endmodule

// File: rtl/ecc_log_regmux.sv
module ecc_log_regmux
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W    = 33,
    parameter int GRAIN_LSB = 7,
    parameter int SYN_W     = 8
) (
    input  logic [2:0]                  sel,
    input  logic [STS_W-1:0]            sts,
    input  logic [STS_W-1:0]            cmd,
    input  logic [ADDR_W-GRAIN_LSB-1:0] line_q,
    input  logic                        chan_q,
    input  logic [SYN_W-1:0]            syn_q,
    output logic [31:0]                 rdata
);

    localparam int EXT_W = ADDR_W - 32;

    logic [ADDR_W-1:0] full_adr;
    logic [31:0]       adr_word;
    logic [31:0]       ext_word;

    always_comb begin
        full_adr = {line_q, {GRAIN_LSB{1'b0}}};
        adr_word = full_adr[31:0];
        adr_word[0] = chan_q;
        ext_word = '0;
        ext_word[EXT_W-1:0] = full_adr[ADDR_W-1:32];
    end

    always_comb begin
        case (reg_sel_e'(sel))
            SEL_STS: rdata = {{(32-STS_W){1'b0}}, sts};
            SEL_CMD: rdata = {{(32-STS_W){1'b0}}, cmd};
            SEL_ADR: rdata = adr_word;
            SEL_EXT: rdata = ext_word;
            SEL_SYN: rdata = {{(32-SYN_W){1'b0}}, syn_q};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W    = 33,
    parameter int GRAIN_LSB = 7,
    parameter int SYN_W     = 8,
    localparam int LINE_W   = ADDR_W - GRAIN_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_evt,
    input  logic              ue_evt,
    input  logic [LINE_W-1:0] err_line,
    input  logic              err_chan,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              thermal_evt,
    input  logic              lock_evt,
    input  logic              refto_evt,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              serr
);

    logic [STS_W-1:0]  evt_vec;
    logic [STS_W-1:0]  sts_q;
    logic [STS_W-1:0]  cmd_q;
    logic [LINE_W-1:0] line_q;
    logic              chan_q;
    logic [SYN_W-1:0]  syn_q;
    logic              sts_wr;
    logic              cmd_wr;

    always_comb begin
        evt_vec          = '0;
        evt_vec[B_CE]    = ce_evt;
        evt_vec[B_UE]    = ue_evt;
        evt_vec[B_REFTO] = refto_evt;
        evt_vec[B_LOCK]  = lock_evt;
        evt_vec[B_THERM] = thermal_evt;
        sts_wr = reg_wr && (reg_addr == SEL_STS);
        cmd_wr = reg_wr && (reg_addr == SEL_CMD);
    end

    ecc_log_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_vec),
        .clr_wr   (sts_wr),
        .clr_data (reg_wdata),
        .sts      (sts_q)
    );

    ecc_log_capture #(
        .LINE_W (LINE_W),
        .SYN_W  (SYN_W)
    ) u_cap (
        .clk     (clk),
        .rst     (rst),
        .ce_evt  (ce_evt),
        .ue_evt  (ue_evt),
        .ce_held (sts_q[B_CE]),
        .ue_held (sts_q[B_UE]),
        .line_in (err_line),
        .chan_in (err_chan),
        .syn_in  (err_syn),
        .line_q  (line_q),
        .chan_q  (chan_q),
        .syn_q   (syn_q)
    );

    ecc_log_serr u_serr (
        .clk    (clk),
        .rst    (rst),
        .cmd_wr (cmd_wr),
        .wdata  (reg_wdata),
        .sts    (sts_q),
        .cmd    (cmd_q),
        .serr   (serr)
    );

    ecc_log_regmux #(
        .ADDR_W    (ADDR_W),
        .GRAIN_LSB (GRAIN_LSB),
        .SYN_W     (SYN_W)
    ) u_mux (
        .sel    (reg_addr),
        .sts    (sts_q),
        .cmd    (cmd_q),
        .line_q (line_q),
        .chan_q (chan_q),
        .syn_q  (syn_q),
        .rdata  (reg_rdata)
    );

endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
    import ecc_log_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_evt,
    input logic              ue_evt,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [15:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic [STS_W-1:0]  sts,
    input logic [STS_W-1:0]  cmd,
    input logic [LINE_W-1:0] line_q,
    input logic              serr
);

    logic sts_wr;
    assign sts_wr = reg_wr && (reg_addr == SEL_STS);

    // R1
    sts_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == SEL_STS) |-> ((reg_rdata & ~{16'h0, STS_MASK}) == 32'h0));

    // R2
    ce_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (sts[B_CE] && sts_wr && reg_wdata[B_CE] && !ce_evt) |=> !sts[B_CE]);

    // R2
    ue_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sts[B_UE] && !(sts_wr && reg_wdata[B_UE])) |=> sts[B_UE]);

    // R3
    ce_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ce_evt |=> sts[B_CE]);

    // R3
    ue_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ue_evt |=> sts[B_UE]);

    // R5
    serr_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (serr == $past(|(sts & cmd))));

    // R11
    ue_details_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sts[B_UE] |=> $stable(line_q));

endmodule

bind ecc_err_log ecc_err_log_chk #(
    .LINE_W (LINE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_evt    (ce_evt),
    .ue_evt    (ue_evt),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sts       (sts_q),
    .cmd       (cmd_q),
    .line_q    (line_q),
    .serr      (serr)
);

// File: tb/ecc_err_log_bench.sv
module ecc_err_log_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_evt = 0, ue_evt = 0;
    logic [25:0] err_line = '0;
    logic        err_chan = 0;
    logic [7:0]  err_syn = '0;
    logic        thermal_evt = 0, lock_evt = 0, refto_evt = 0;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        serr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ecc_err_log u_ecc_err_log (
        .clk(clk), .rst(rst), .ce_evt(ce_evt), .ue_evt(ue_evt),
        .err_line(err_line), .err_chan(err_chan), .err_syn(err_syn),
        .thermal_evt(thermal_evt), .lock_evt(lock_evt), .refto_evt(refto_evt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .serr(serr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] val);
        reg_addr = idx;
        #1;
        val = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    // one-cycle ECC event with details
    task automatic ecc(input logic ce, input logic ue, input logic [25:0] ln,
                       input logic ch, input logic [7:0] sy);
        @(negedge clk);
        ce_evt = ce; ue_evt = ue; err_line = ln; err_chan = ch; err_syn = sy;
        @(negedge clk);
        ce_evt = 0; ue_evt = 0; err_line = '0; err_chan = 0; err_syn = '0;
    endtask

    function automatic logic [31:0] adr_exp(input logic [25:0] ln, input logic ch);
        return {ln[24:0], 6'b0, ch};
    endfunction

    task automatic check_details(input string req, input logic [25:0] ln,
                                 input logic ch, input logic [7:0] sy);
        logic [31:0] v;
        rd(3'd2, v); chk(req, v, adr_exp(ln, ch));
        rd(3'd3, v); chk(req, v, {31'b0, ln[25]});
        rd(3'd4, v); chk(req, v, {24'b0, sy});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), v); chk("R13", v, 32'h0);
        end
        chk("R13 serr", {31'b0, serr}, 32'h0);
    endtask

    task automatic t_sources();
        logic [31:0] v;
        @(negedge clk); thermal_evt = 1;
        @(negedge clk); thermal_evt = 0;
        rd(3'd0, v); chk("R1 thermal bit11", v, 32'h0800);
        @(negedge clk); lock_evt = 1; refto_evt = 1;
        @(negedge clk); lock_evt = 0; refto_evt = 0;
        rd(3'd0, v); chk("R1 lock/refto bits9/8", v, 32'h0B00);
        wr(3'd0, 16'h0200);
        rd(3'd0, v); chk("R2 clear lock only", v, 32'h0900);
        wr(3'd0, 16'h0000);
        rd(3'd0, v); chk("R2 write zero no effect", v, 32'h0900);
        wr(3'd0, 16'hFFFF);
        rd(3'd0, v); chk("R2 clear all", v, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        ecc(1, 0, 26'h0000100, 0, 8'h11);
        @(negedge clk);
        ce_evt = 1; reg_wr = 1; reg_addr = 3'd0; reg_wdata = 16'h0001;
        @(negedge clk);
        ce_evt = 0; reg_wr = 0; reg_wdata = '0;
        rd(3'd0, v); chk("R3 set beats clear", v, 32'h0001);
        wr(3'd0, 16'hFFFF);
    endtask

    task automatic t_cmd();
        logic [31:0] v;
        wr(3'd1, 16'hFFFF);
        rd(3'd1, v); chk("R4 cmd mask", v, 32'h0B03);
        wr(3'd1, 16'h0100);
        rd(3'd1, v); chk("R4 cmd write", v, 32'h0100);
    endtask

    task automatic t_serr();
        // cmd enables only refresh timeout (bit 8)
        @(negedge clk); thermal_evt = 1;
        @(negedge clk); thermal_evt = 0;
        @(negedge clk);
        chk("R5 disabled source no serr", {31'b0, serr}, 32'h0);
        @(negedge clk); refto_evt = 1;
        @(negedge clk); refto_evt = 0;
        chk("R5 serr registered delay", {31'b0, serr}, 32'h0);
        @(negedge clk);
        chk("R5 serr asserted", {31'b0, serr}, 32'h1);
        wr(3'd0, 16'h0100);
        @(negedge clk);
        chk("R5 serr drops after clear", {31'b0, serr}, 32'h0);
        wr(3'd0, 16'hFFFF);
        wr(3'd1, 16'h0000);
    endtask

    task automatic t_capture();
        logic [31:0] v;
        ecc(1, 0, 26'h2345678, 1, 8'h5A);
        check_details("R6 R7 R8 R9 first ce", 26'h2345678, 1, 8'h5A);
        ecc(1, 0, 26'h0ABCDEF, 0, 8'h33);
        check_details("R9 second ce ignored", 26'h2345678, 1, 8'h5A);
        ecc(0, 1, 26'h1555555, 0, 8'hC3);
        check_details("R10 ue over ce", 26'h1555555, 0, 8'hC3);
        rd(3'd0, v); chk("R10 both flags", v, 32'h0003);
        ecc(1, 0, 26'h00000FF, 1, 8'h01);
        check_details("R11 ce after ue", 26'h1555555, 0, 8'hC3);
        ecc(0, 1, 26'h3FFFFFF, 1, 8'hFF);
        check_details("R11 ue after ue", 26'h1555555, 0, 8'hC3);
        wr(3'd0, 16'hFFFF);
    endtask

    task automatic t_simul();
        logic [31:0] v;
        ecc(1, 1, 26'h2AAAAAA, 1, 8'h96);
        check_details("R12 simultaneous", 26'h2AAAAAA, 1, 8'h96);
        rd(3'd0, v); chk("R12 both flags", v, 32'h0003);
        rd(3'd5, v); chk("R1 unmapped index zero", v, 32'h0);
        wr(3'd0, 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_sources();
        t_set_wins();
        t_cmd();
        t_serr();
        t_capture();
        t_simul();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule